// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a four-wire serial link that loads and reads a bank of byte-wide configuration registers. A host lowers the select line, then clocks in a 16-bit frame: a direction bit, a six-bit register number, one spare bit that is discarded, and a data byte. The address and the data travel most significant bit first. Write frames may keep going: each further group of eight clocks writes the next higher register. A read frame returns one byte on the data-out line, and it does so only when software has first set a read-back permission bit.

The serial pins are oversampled by the system clock through synchronisers, so every register and every decision lives in one clock domain. The shared data line is modelled as a data-in, a data-out and an output-enable. One 16-bit register spans two addresses, with its high byte at the lower address. Its high byte is parked in a shadow until the low byte arrives, and the two halves then change on the same cycle. The 16-bit value and the read-back permission bit are brought out as ports.

Top module: `spi_cfg_port`

## Requirements
- R1: A frame whose first bit is 0 writes its final eight bits into the register selected by bits 2 to 7 of the frame (MSB first), and a later read of that register returns the byte.
- R2: The eighth frame bit has no effect: its value changes neither the target register nor the data stored.
- R3: If the select line rises before the eighth data bit of a byte, that byte is discarded and the target register keeps its old value.
- R4: While the select line stays low after a write byte, each further eight clocks write the next byte to the next higher address.
- R5: With read-back enabled, a frame whose first bit is 1 drives the addressed register on the data-out line, MSB first, changing after falling clock edges, so that the host samples it on clock rises 9 to 16.
- R6: With read-back disabled, a read frame leaves the output-enable low for the whole frame and writes nothing.
- R7: A read never bursts: clocks after the sixteenth neither drive the output nor write any register.
- R8: The 16-bit register has its high byte at address 0x10 and its low byte at 0x11; a write to 0x10 alone leaves the port and read-back value unchanged, and the full value changes only when 0x11 is written.
- R9: The output-enable is high only while a permitted read is shifting out its byte, and low whenever the select line is high.
- R10: After reset every byte register reads 0x00, the 16-bit register is 0x0123 and read-back is disabled.
- R11: The read-back permission is bit 3 of register 0x3A and is reported on `cfg_readback_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select from the host |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | High while the block drives the shared data line |
| cfg_wide | output | 16 | Committed value of the two-byte register |
| cfg_readback_en | output | 1 | Read-back permission bit |

## Verification
The bench goes after the frame edges: a byte cut off after four data bits, which a design committing partial shifts would store as a shifted value, and a burst ending in a partial byte, where a careless counter writes a fourth register. It sends reads with trailing clocks, which a design that auto-increments reads would answer with a second drive or a stray write to the next address. It writes the high half of the two-byte register alone, which an unshadowed design would expose at once. It also sends a read before permission is granted, which a leaky design would answer by driving the line, and it sets the ignored bit so that an off-by-one address decode shows up.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int FRAME_W  = 2 * DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam addr_t RB_ADDR = 6'h3A;
  localparam int    RB_BIT  = 3;
  localparam addr_t WIDE_HI = 6'h10;
  localparam addr_t WIDE_LO = WIDE_HI + 6'd1;
  localparam logic [2*DATA_W-1:0] WIDE_DEFAULT = 16'h0123;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;
    always_comb ff_d = {ff_q[STAGES-2:0], d[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL[g]}};
      else        ff_q <= ff_d;
    end
    assign q[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_s,
  input  logic  sck_s,
  input  logic  mosi_s,
  input  logic  rb_en,
  input  byte_t rd_data,
  output addr_t rd_addr,
  output logic  wr_en,
  output addr_t wr_addr,
  output byte_t wr_data,
  output logic  miso,
  output logic  oe
);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] BYTE_FIRST = CNT_W'(DATA_W);

  logic             sck_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-2:0] sh_q, sh_d;
  logic             rnw_q, rnw_d;
  addr_t            addr_q, addr_d;
  logic             act_q, act_d;
  logic             stall_q, stall_d;
  byte_t            osr_q, osr_d;
  logic             miso_q, miso_d;
  logic             wr_q, wr_d;
  addr_t            wa_q, wa_d;
  byte_t            wd_q, wd_d;
  logic             rise, fall;

  assign rise    = sck_s & ~sck_q;
  assign fall    = ~sck_s & sck_q;
  assign rd_addr = sh_q[ADDR_W-1:0];

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rnw_d   = rnw_q;
    addr_d  = addr_q;
    act_d   = act_q;
    stall_d = stall_q;
    osr_d   = osr_q;
    miso_d  = miso_q;
    wr_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    if (cs_s) begin
      cnt_d   = '0;
      act_d   = 1'b0;
      stall_d = 1'b0;
      miso_d  = 1'b0;
    end else if (rise && !stall_q) begin
      sh_d  = {sh_q[DATA_W-3:0], mosi_s};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == HDR_LAST) begin
        // sh_q holds direction bit and address; the bit now on mosi is spare
        rnw_d  = sh_q[DATA_W-2];
        addr_d = sh_q[ADDR_W-1:0];
        if (sh_q[DATA_W-2]) begin
          if (rb_en) begin
            act_d = 1'b1;
            osr_d = rd_data;
          end else begin
            stall_d = 1'b1;
          end
        end
      end
      if (cnt_q == BYTE_LAST) begin
        if (!rnw_q) begin
          wr_d   = 1'b1;
          wa_d   = addr_q;
          wd_d   = {sh_q, mosi_s};
          addr_d = addr_q + 1'b1;
          cnt_d  = BYTE_FIRST;
        end else begin
          act_d   = 1'b0;
          stall_d = 1'b1;
          miso_d  = 1'b0;
        end
      end
    end else if (fall && act_q) begin
      miso_d = osr_q[DATA_W-1];
      osr_d  = {osr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      act_q   <= 1'b0;
      stall_q <= 1'b0;
      osr_q   <= '0;
      miso_q  <= 1'b0;
      wr_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else begin
      sck_q   <= sck_s;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rnw_q   <= rnw_d;
      addr_q  <= addr_d;
      act_q   <= act_d;
      stall_q <= stall_d;
      osr_q   <= osr_d;
      miso_q  <= miso_d;
      wr_q    <= wr_d;
      wa_q    <= wa_d;
      wd_q    <= wd_d;
    end
  end

  assign wr_en   = wr_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign miso    = miso_q;
  assign oe      = act_q;
endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
  import spi_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  byte_t wr_data,
  input  addr_t rd_addr,
  output byte_t rd_data,
  output logic [2*DATA_W-1:0] wide,
  output logic  rb_en
);
  byte_t bank_q [NUM_REGS];
  byte_t shadow_q, shadow_d;
  logic [2*DATA_W-1:0] wide_q, wide_d;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic  hit;
    byte_t nxt;
    assign hit = wr_en && (wr_addr == addr_t'(g)) &&
                 (addr_t'(g) != WIDE_HI) && (addr_t'(g) != WIDE_LO);
    always_comb nxt = hit ? wr_data : bank_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= '0;
      else        bank_q[g] <= nxt;
    end
  end

  always_comb begin
    shadow_d = shadow_q;
    wide_d   = wide_q;
    if (wr_en && wr_addr == WIDE_HI) shadow_d = wr_data;
    if (wr_en && wr_addr == WIDE_LO) wide_d   = {shadow_q, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= WIDE_DEFAULT[2*DATA_W-1:DATA_W];
      wide_q   <= WIDE_DEFAULT;
    end else begin
      shadow_q <= shadow_d;
      wide_q   <= wide_d;
    end
  end

  always_comb begin
    if (rd_addr == WIDE_HI)      rd_data = wide_q[2*DATA_W-1:DATA_W];
    else if (rd_addr == WIDE_LO) rd_data = wide_q[DATA_W-1:0];
    else                         rd_data = bank_q[rd_addr];
  end

  assign wide  = wide_q;
  assign rb_en = bank_q[RB_ADDR][RB_BIT];
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sck,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_oe,
  output logic [15:0] cfg_wide,
  output logic        cfg_readback_en
);
  logic [1:0] rst_ff_q;
  logic       rst_s;
  logic       cs_s, sck_s, mosi_s;
  logic       rb_en, wr_en;
  addr_t      wr_addr, rd_addr;
  byte_t      wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= 2'b00;
    else        rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_s = rst_ff_q[1];

  spi_cfg_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_s),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q({cs_s, sck_s, mosi_s})
  );

  spi_cfg_frame u_frame (
    .clk(clk), .rst_n(rst_s), .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .rb_en(rb_en), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(spi_miso), .oe(spi_miso_oe)
  );

  spi_cfg_regbank u_bank (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wide(cfg_wide), .rb_en(rb_en)
  );

  assign cfg_readback_en = rb_en;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
  import spi_cfg_pkg::*;
(
  input logic        clk,
  input logic        rst_s,
  input logic        cs_s,
  input logic        spi_miso_oe,
  input logic        cfg_readback_en,
  input logic        wr_en,
  input addr_t       wr_addr,
  input logic [15:0] cfg_wide
);
  p_oe_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_s)
    spi_miso_oe |-> cfg_readback_en);

  p_oe_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_s)
    cs_s |=> !spi_miso_oe);

  p_wide_commit_low_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(cfg_wide) |-> ($past(wr_en) && $past(wr_addr) == WIDE_LO));

  p_write_pulse_r4: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> !wr_en);

  p_no_write_reading_r7: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |-> !spi_miso_oe);
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
  .clk(clk), .rst_s(rst_s), .cs_s(cs_s), .spi_miso_oe(spi_miso_oe),
  .cfg_readback_en(cfg_readback_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg_wide(cfg_wide)
);

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
  localparam int HALF = 8;
  localparam int NV   = 9;
  // {is_read, 0, addr[5:0], data or expected[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'h05, 8'h3C}, {1'b1, 1'b0, 6'h05, 8'h3C},
    {1'b0, 1'b0, 6'h20, 8'hA1}, {1'b1, 1'b0, 6'h20, 8'hA1},
    {1'b1, 1'b0, 6'h3A, 8'h08}, {1'b0, 1'b0, 6'h3F, 8'hFF},
    {1'b1, 1'b0, 6'h3F, 8'hFF}, {1'b1, 1'b0, 6'h00, 8'h00},
    {1'b1, 1'b0, 6'h21, 8'h00}
  };

  logic clk, rst_n, cs_n, sck, mosi;
  logic miso, miso_oe, rb;
  logic [15:0] wide;
  int checks, errors;
  bit done;

  spi_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .cfg_wide(wide),
    .cfg_readback_en(rb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [47:0] bits, input int n,
                      output logic [7:0] rd, output bit oe_any, output bit oe_late);
    rd = '0; oe_any = 0; oe_late = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) rd = {rd[6:0], miso};
      if (miso_oe) begin
        oe_any = 1;
        if (i >= 16 || i < 8) oe_late = 1;
      end
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] r; bit o1, o2;
    xfer({16'h0, 1'b0, a, 1'b0, d}, 16, r, o1, o2);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bit o1, o2;
    xfer({16'h0, 1'b1, a, 1'b0, 8'h00}, 16, d, o1, o2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    bit oa, ol;
    checks = 0; errors = 0; done = 0;
    cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R10 and R9: reset state
    chk("R10 wide default", wide, 16'h0123);
    chk("R10 readback off", rb, 0);
    chk("R9 oe idle", miso_oe, 0);

    // R6: read refused while disabled
    xfer({32'h0, 1'b1, 6'h3A, 1'b0, 8'h00}, 16, r, oa, ol);
    chk("R6 no drive when disabled", oa, 0);
    chk("R6 no write on refused read", rb, 0);

    // R11: permission bit at 0x3A bit 3
    wr(6'h3A, 8'h08);
    chk("R11 readback enable", rb, 1);

    // R1 and R5: vector table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][15]) begin
        xfer({32'h0, 1'b1, VEC[k][13:8], 1'b0, 8'h00}, 16, r, oa, ol);
        chk("R5 read data", r, VEC[k][7:0]);
        chk("R5 oe window", {oa, ol}, 2'b10);
      end else begin
        wr(VEC[k][13:8], VEC[k][7:0]);
      end
    end
    chk("R9 oe idle after reads", miso_oe, 0);

    // R2: spare bit set
    xfer({32'h0, 1'b0, 6'h06, 1'b1, 8'h5A}, 16, r, oa, ol);
    rd(6'h06, r); chk("R2 spare bit target", r, 8'h5A);
    rd(6'h07, r); chk("R2 neighbour untouched", r, 8'h00);

    // R3: cut-short byte discarded
    xfer({36'h0, 1'b0, 6'h05, 1'b0, 4'hF}, 12, r, oa, ol);
    rd(6'h05, r); chk("R3 abort keeps value", r, 8'h3C);

    // R4: burst with a trailing partial byte
    xfer({12'h0, 1'b0, 6'h08, 1'b0, 8'h11, 8'h22, 8'h33, 4'hF}, 36, r, oa, ol);
    rd(6'h08, r); chk("R4 burst byte0", r, 8'h11);
    rd(6'h09, r); chk("R4 burst byte1", r, 8'h22);
    rd(6'h0A, r); chk("R4 burst byte2", r, 8'h33);
    rd(6'h0B, r); chk("R4 partial tail dropped", r, 8'h00);

    // R7: read with extra clocks
    xfer({24'h0, 1'b1, 6'h06, 1'b0, 8'h00, 8'h00}, 24, r, oa, ol);
    chk("R7 read data", r, 8'h5A);
    chk("R7 no drive after byte", ol, 0);
    rd(6'h06, r); chk("R7 no write to addr", r, 8'h5A);
    rd(6'h07, r); chk("R7 no write to next", r, 8'h00);

    // R8: shadowed two-byte register
    wr(6'h10, 8'hBE);
    chk("R8 high alone no change", wide, 16'h0123);
    rd(6'h10, r); chk("R8 readback committed high", r, 8'h01);
    wr(6'h11, 8'hEF);
    chk("R8 commit on low", wide, 16'hBEEF);
    xfer({24'h0, 1'b0, 6'h10, 1'b0, 8'h12, 8'h34}, 24, r, oa, ol);
    chk("R8 burst commit", wide, 16'h1234);
    rd(6'h11, r); chk("R8 low readback", r, 8'h34);
    chk("R9 oe idle at end", miso_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule